// File: doc/BRIEF.md
# Register-Read Packet Receive Queue

This block takes 32-bit words from an AXI4-Stream slave port and holds them in a word queue. Software then drains the packets through a small word-addressed register port. A packet ends on the beat that carries TLAST. When that beat is accepted, the packet's byte length (four bytes per beat) goes into a separate length queue, and the packet's words start to count toward the occupancy register.

Software drains one packet at a time. It reads the length register first, which pops that packet's byte count, and then reads the data register once per word. The block enforces this order. A data read with no length read before it returns zero, and so does a data read past the end of the packet; both raise an over-read flag. A length read that leaves words of the previous packet unread raises an under-read flag. Any read while the queue holds no complete word (for data) or no length (for length) returns zero and raises an underrun flag. Writing the key 0xA5 to the flush register empties everything.

Status bits are cleared by writing 1 to them. An enable register masks them onto a single interrupt line.

Top module: `pkt_rx_fifo`

Register addresses (word index on `reg_addr`): 0 status (write-1-to-clear), 1 interrupt enable, 2 flush key, 3 occupancy, 4 data, 5 length. Read data appears on `reg_rdata` one clock after the cycle in which `reg_rd` is high, and holds until the next read.

## Requirements
- R1: After reset, `s_ready` is 1, `irq` is 0, the status register reads 0 and the occupancy register reads 0.
- R2: A beat is accepted when `s_valid` and `s_ready` are both high. `s_ready` goes low once DATA_DEPTH words are stored. Accepting a beat with `s_last` high sets status bit 26 (packet arrived).
- R3: The occupancy register returns the number of stored words that belong to packets whose last beat has arrived. Words of a packet still arriving are not counted.
- R4: A length read returns 4 times the beat count of the oldest packet not yet opened. Packets are served in arrival order.
- R5: After a length read, each data read returns the next word of that packet, in arrival order, and removes it.
- R6: A data read while the occupancy is 0, or a length read while no length is stored, returns 0, removes nothing and sets status bit 29 (underrun).
- R7: A data read while the occupancy is nonzero but the open packet has no words left (or no length read has opened it) returns 0, sets status bit 30 (over-read) and leaves the occupancy unchanged.
- R8: A length read while the open packet still has unread words sets status bit 31 (under-read). The read still returns the next packet's length.
- R9: Writing exactly 0xA5 to the flush register clears the occupancy and the length queue and sets status bit 23 (flush done). Any other value has no effect.
- R10: Writing the status register clears each bit whose write-data bit is 1 and leaves the others. If an event sets a bit in the same cycle, the event wins.
- R11: `irq` is high exactly when some status bit and the same bit of the enable register are both 1. The enable register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 32 | Stream data word |
| s_valid | input | 1 | Stream word valid |
| s_last | input | 1 | Stream word ends a packet |
| s_ready | output | 1 | Queue can take a word |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| irq | output | 1 | Masked status interrupt |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high in the same cycle, and that no packet is longer than DATA_DEPTH beats. A longer packet would fill the queue without ever completing, and the stream would stall for good. The stimulus uses one strobe per register task, and it keeps packets short, apart from one packet of exactly DATA_DEPTH beats that checks the full condition. Misuse reads are issued on purpose, and each is followed by reads of occupancy or data that show nothing was removed.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam int WORD_W = 32;

  localparam logic [2:0] ADR_STATUS = 3'd0;
  localparam logic [2:0] ADR_ENABLE = 3'd1;
  localparam logic [2:0] ADR_FLUSH  = 3'd2;
  localparam logic [2:0] ADR_OCC    = 3'd3;
  localparam logic [2:0] ADR_DATA   = 3'd4;
  localparam logic [2:0] ADR_LEN    = 3'd5;

  localparam int BIT_UNDERREAD = 31;
  localparam int BIT_OVERREAD  = 30;
  localparam int BIT_UNDERRUN  = 29;
  localparam int BIT_ARRIVED   = 26;
  localparam int BIT_FLUSHED   = 23;

  localparam logic [WORD_W-1:0] FLUSH_KEY = 32'h0000_00A5;

  localparam logic [WORD_W-1:0] STATUS_USED =
    (32'h1 << BIT_UNDERREAD) | (32'h1 << BIT_OVERREAD) |
    (32'h1 << BIT_UNDERRUN)  | (32'h1 << BIT_ARRIVED)  |
    (32'h1 << BIT_FLUSHED);

  // bytes carried by a number of 32-bit beats
  function automatic int unsigned beats_to_bytes(int unsigned beats);
    return beats * 4;
  endfunction

  // words held in a byte length
  function automatic int unsigned bytes_to_words(int unsigned bytes);
    return bytes / 4;
  endfunction
endpackage

// File: rtl/rx_word_store.sv
module rx_word_store #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full  = (fill == CW'(DEPTH));
  assign empty = (fill == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= din;
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rx_len_counter.sv
module rx_len_counter #(
  parameter int CW = 7,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          beat,
  input  logic          last,
  output logic          commit,
  output logic [CW-1:0] commit_beats,
  output logic [LW-1:0] commit_bytes
);
  import pkt_rx_pkg::*;

  logic [CW-1:0] so_far;

  assign commit       = beat && last && !flush;
  assign commit_beats = so_far + 1'b1;
  assign commit_bytes = LW'(beats_to_bytes(int'(commit_beats)));

  always_ff @(posedge clk) begin
    if (!rst_n || flush)  so_far <= '0;
    else if (commit)      so_far <= '0;
    else if (beat)        so_far <= so_far + 1'b1;
  end
endmodule

// File: rtl/rx_read_seq.sv
module rx_read_seq #(
  parameter int CW = 7,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          data_req,
  input  logic          len_req,
  input  logic [CW-1:0] committed,
  input  logic          len_avail,
  input  logic [LW-1:0] len_head,
  output logic          data_pop,
  output logic          len_pop,
  output logic          ev_underrun,
  output logic          ev_overread,
  output logic          ev_underread
);
  import pkt_rx_pkg::*;

  logic [CW-1:0] left_q;
  logic          data_starved, len_starved;

  assign data_starved = (committed == '0);
  assign len_starved  = !len_avail;

  assign data_pop     = data_req && !data_starved && (left_q != '0);
  assign len_pop      = len_req && !len_starved;
  assign ev_underrun  = (data_req && data_starved) || (len_req && len_starved);
  assign ev_overread  = data_req && !data_starved && (left_q == '0);
  assign ev_underread = len_pop && (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || flush)
      left_q <= '0;
    else if (len_pop)
      left_q <= CW'(bytes_to_words(int'(len_head)));
    else if (data_pop)
      left_q <= left_q - 1'b1;
  end

  p_one_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_pop, ev_overread, data_req && data_starved}));
  p_open_after_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (len_pop && !flush && len_head != '0) |=> (left_q != '0));
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo #(
  parameter int DATA_DEPTH = 64,
  parameter int LEN_DEPTH  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] s_data,
  input  logic        s_valid,
  input  logic        s_last,
  output logic        s_ready,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  import pkt_rx_pkg::*;

  localparam int CW = $clog2(DATA_DEPTH + 1);
  localparam int LW = CW + 2;

  logic              beat, flush;
  logic              data_full, data_empty, len_full, len_empty;
  logic [WORD_W-1:0] data_head;
  logic [LW-1:0]     len_head;
  logic              commit;
  logic [CW-1:0]     commit_beats;
  logic [LW-1:0]     commit_bytes;
  logic              data_req, len_req, data_pop, len_pop;
  logic              ev_underrun, ev_overread, ev_underread;
  logic [CW-1:0]     committed_q;
  logic [WORD_W-1:0] status_q, enable_q, status_set, status_clr;

  assign s_ready  = !data_full && !len_full;
  assign beat     = s_valid && s_ready;
  assign flush    = reg_wr && (reg_addr == ADR_FLUSH) && (reg_wdata == FLUSH_KEY);
  assign data_req = reg_rd && (reg_addr == ADR_DATA);
  assign len_req  = reg_rd && (reg_addr == ADR_LEN);

  rx_word_store #(.W(WORD_W), .DEPTH(DATA_DEPTH)) u_data_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(beat), .din(s_data), .pop(data_pop),
    .dout(data_head), .full(data_full), .empty(data_empty));

  rx_word_store #(.W(LW), .DEPTH(LEN_DEPTH)) u_len_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(commit), .din(commit_bytes), .pop(len_pop),
    .dout(len_head), .full(len_full), .empty(len_empty));

  rx_len_counter #(.CW(CW), .LW(LW)) u_len_count (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .beat(beat), .last(s_last),
    .commit(commit), .commit_beats(commit_beats), .commit_bytes(commit_bytes));

  rx_read_seq #(.CW(CW), .LW(LW)) u_read_seq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .data_req(data_req), .len_req(len_req),
    .committed(committed_q), .len_avail(!len_empty), .len_head(len_head),
    .data_pop(data_pop), .len_pop(len_pop),
    .ev_underrun(ev_underrun), .ev_overread(ev_overread), .ev_underread(ev_underread));

  // words of finished packets still waiting
  always_ff @(posedge clk) begin
    if (!rst_n || flush)
      committed_q <= '0;
    else
      committed_q <= committed_q + (commit ? commit_beats : '0) - CW'(data_pop);
  end

  always_comb begin
    status_set = '0;
    status_set[BIT_UNDERREAD] = ev_underread;
    status_set[BIT_OVERREAD]  = ev_overread;
    status_set[BIT_UNDERRUN]  = ev_underrun;
    status_set[BIT_ARRIVED]   = commit;
    status_set[BIT_FLUSHED]   = flush;
    status_clr = (reg_wr && reg_addr == ADR_STATUS) ? reg_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= ((status_q & ~status_clr) | status_set) & STATUS_USED;
      if (reg_wr && reg_addr == ADR_ENABLE) enable_q <= reg_wdata;
    end
  end

  assign irq = |(status_q & enable_q);

  always_ff @(posedge clk) begin
    if (!rst_n)
      reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        ADR_STATUS: reg_rdata <= status_q;
        ADR_ENABLE: reg_rdata <= enable_q;
        ADR_OCC:    reg_rdata <= WORD_W'(committed_q);
        ADR_DATA:   reg_rdata <= data_pop ? data_head : '0;
        ADR_LEN:    reg_rdata <= len_pop ? WORD_W'(len_head) : '0;
        default:    reg_rdata <= '0;
      endcase
    end
  end

  p_arrived_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && s_last && !flush) |=> status_q[BIT_ARRIVED]);
  p_occ_has_words_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (committed_q != '0) |-> !data_empty);
  p_underrun_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_req && committed_q == '0) |=> (reg_rdata == '0) && status_q[BIT_UNDERRUN]);
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (committed_q == '0) && len_empty && status_q[BIT_FLUSHED]);
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq);
  p_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));
endmodule

// File: tb/test_pkt_rx_fifo.sv
module test_pkt_rx_fifo;
  localparam int DEPTH = 64;
  localparam int N_PKT = 4;
  localparam int PKT_BEATS [N_PKT] = '{1, 3, 2, 5};

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] s_data = 0;
  logic        s_valid = 0, s_last = 0;
  logic        s_ready;
  logic        reg_rd = 0, reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq;

  int errors = 0, checks = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  pkt_rx_fifo #(.DATA_DEPTH(DEPTH), .LEN_DEPTH(16)) i_pkt_rx_fifo (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  function automatic logic [31:0] word_of(int pkt, int idx);
    return {pkt[7:0], 8'hC0, idx[15:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] val);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(posedge clk); #1 reg_rd = 0; val = reg_rdata;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic beat(logic [31:0] d, logic last);
    @(negedge clk); s_valid = 1; s_data = d; s_last = last;
    while (!s_ready) @(negedge clk);
    @(posedge clk); #1 s_valid = 0; s_last = 0;
  endtask

  task automatic send(int pkt, int n);
    for (int i = 0; i < n; i++) beat(word_of(pkt, i), i == n - 1);
  endtask

  task automatic drain(string req, int pkt, int n);
    logic [31:0] x;
    rd(3'd5, x); chk({req, " length"}, x, 32'(n * 4));
    for (int i = 0; i < n; i++) begin
      rd(3'd4, x); chk({req, " word"}, x, word_of(pkt, i));
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int total;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 s_ready", 32'(s_ready), 1);
    chk("R1 irq", 32'(irq), 0);
    rd(3'd0, v); chk("R1 status", v, 0);
    rd(3'd3, v); chk("R1 occupancy", v, 0);

    // table walk: send all packets, then drain in order
    total = 0;
    for (int p = 0; p < N_PKT; p++) begin
      send(p, PKT_BEATS[p]);
      total += PKT_BEATS[p];
    end
    rd(3'd0, v); chk("R2 arrived bit 26", v, 32'h0400_0000);
    rd(3'd3, v); chk("R3 occupancy", v, 32'(total));
    beat(word_of(9, 0), 0); beat(word_of(9, 1), 0);
    rd(3'd3, v); chk("R3 partial not counted", v, 32'(total));
    for (int p = 0; p < N_PKT; p++) drain("R4 R5 table", p, PKT_BEATS[p]);
    rd(3'd3, v); chk("R3 drained", v, 0);
    beat(word_of(9, 2), 1);
    rd(3'd3, v); chk("R3 partial completes", v, 3);
    drain("R4 R5 late packet", 9, 3);

    // R10 write-1-to-clear, zero write leaves bits
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R10 zero write keeps", v, 32'h0400_0000);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R10 clear", v, 0);

    // R6 underrun
    rd(3'd4, v); chk("R6 data empty returns 0", v, 0);
    rd(3'd0, v); chk("R6 underrun bit 29", v, 32'h2000_0000);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R6 length empty returns 0", v, 0);
    rd(3'd0, v); chk("R6 length underrun bit 29", v, 32'h2000_0000);
    wr(3'd0, 32'hFFFF_FFFF);

    // R7 over-read
    send(20, 2); send(21, 1);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R7 data before length", v, 0);
    rd(3'd3, v); chk("R7 occupancy kept", v, 3);
    rd(3'd0, v); chk("R7 over-read bit 30", v, 32'h4000_0000);
    wr(3'd0, 32'hFFFF_FFFF);
    drain("R7 first packet", 20, 2);
    rd(3'd4, v); chk("R7 read past packet", v, 0);
    rd(3'd0, v); chk("R7 over-read past end", v, 32'h4000_0000);
    rd(3'd3, v); chk("R7 occupancy after over-read", v, 1);
    drain("R7 second packet", 21, 1);
    wr(3'd0, 32'hFFFF_FFFF);

    // R8 under-read
    send(30, 3); send(31, 1);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R8 first length", v, 12);
    rd(3'd4, v); chk("R8 first word", v, word_of(30, 0));
    rd(3'd5, v); chk("R8 next length still returned", v, 4);
    rd(3'd0, v); chk("R8 under-read bit 31", v, 32'h8000_0000);

    // R9 flush key
    wr(3'd2, 32'h0000_005A);
    rd(3'd3, v); chk("R9 wrong key ignored", v, 3);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0000_00A5);
    rd(3'd3, v); chk("R9 occupancy cleared", v, 0);
    rd(3'd0, v); chk("R9 flush done bit 23", v, 32'h0080_0000);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R9 length queue empty", v, 0);
    wr(3'd0, 32'hFFFF_FFFF);

    // R11 interrupt masking
    wr(3'd1, 32'h0400_0000);
    rd(3'd1, v); chk("R11 enable readback", v, 32'h0400_0000);
    chk("R11 irq idle", 32'(irq), 0);
    send(40, 1);
    chk("R11 irq raised", 32'(irq), 1);
    wr(3'd1, 32'h0);
    chk("R11 irq masked", 32'(irq), 0);
    wr(3'd1, 32'h0400_0000);
    wr(3'd0, 32'h0400_0000);
    chk("R11 irq after clear", 32'(irq), 0);
    drain("R11 packet", 40, 1);

    // R2 full queue
    send(50, DEPTH);
    chk("R2 s_ready low when full", 32'(s_ready), 0);
    rd(3'd3, v); chk("R2 full occupancy", v, 32'(DEPTH));
    wr(3'd2, 32'h0000_00A5);
    chk("R2 R9 s_ready after flush", 32'(s_ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule